// File: doc/BRIEF.md
# Memory Type Range Lookup Unit

This block decides which caching behaviour applies to a physical address range. A range arrives as a start address and an exclusive end address. The block returns an 8-bit memory type, or one of two reserved codes. One code means that range resolution is switched off. The other means that the range only partly overlaps a programmed variable region.

Software programs the lookup tables through a write-only register port. The tables are:
- a control word that holds the enables, the default type and whether fixed ranges exist;
- eighty-eight fixed type bytes that cover the first megabyte;
- a parameterised set of base/mask variable regions;
- an optional upper-memory limit. Above 4 GiB and below this limit, memory is treated as write-back.

Lookups use a valid/ready handshake. Each accepted lookup produces one registered result, together with a one-cycle valid strobe.

Top module: `memtype_resolver`

## Requirements
- R1: Until the control word (selector 0x00) has been written at least once since reset, or while its two-bit enable field (bits 11:10) is zero, every lookup returns 0xFF.
- R2: When the fixed-present flag (control bit 8) is set and start is below 0x100000, the result is a fixed byte chosen by start alone. The index is start>>16 below 0x80000, 8+((start-0x80000)>>14) below 0xC0000, and 24+((start-0xC0000)>>12) otherwise. When the flag is clear, such addresses go through the variable path.
- R3: With the fixed path not taken and enable bit 11 (variable regions on) clear, the result is the default type held in control bits 7:0.
- R4: A variable region takes part only when its mask-word bit 11 is set. Its type is bits 7:0 of its base word. Bits 11:0 of base and mask are ignored in address comparison.
- R5: The end address is made inclusive by subtracting one. A region matches an address when (address & mask) equals (base & mask). If the start and the inclusive end disagree about a participating region, the result is 0xFE.
- R6: Regions are scanned from index 0 upward. Two matching types combine as follows: uncacheable (0) with anything gives 0; write-back (6) with write-through (4) gives 4; any other disagreement gives 0. A 0 produced by this combining, or a 0xFE, ends the scan at that region, so later regions are not examined.
- R7: If the scan did not end early, the limit (selector 0x01, bits 39:0) is nonzero, start is at or above 4 GiB and the inclusive end is below the limit, the result is 6.
- R8: Otherwise the combined type of the matching regions is returned, or the default type if no region matched.
- R9: lk_ready is low exactly in cycles with cfg_we high. res_valid pulses high in the cycle after each accepted lookup and only then. res_type holds its value between results.
- R10: Register selectors are as follows. Selector 0x10+w (w = 0..10) writes fixed bytes 8w..8w+7, with byte k of the data going to index 8w+k. Selector 0x40+2i writes region i's base word. Selector 0x41+2i writes region i's mask word, with address bits 39:12 in each. Selectors that are not mapped are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 8 | Register selector |
| cfg_wdata | input | 64 | Register write data |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_start | input | 40 | Range start address |
| lk_end | input | 40 | Range end address, exclusive |
| res_valid | output | 1 | Result strobe |
| res_type | output | 8 | Resolved type or reserved code |

## Verification
A lookup is accepted on the rising edge at which lk_valid and lk_ready are both high. Its type appears on res_type, with res_valid high, from that same edge through the following one. A register write affects lookups accepted from the next edge onward. lk_ready follows cfg_we within the same cycle. The bench drives inputs shortly after each rising edge and samples on the falling edge. At that point it compares the outputs against the expectation it computed one cycle earlier from the inputs then present. It then computes the expectation for the next edge. In this way every result is checked in exactly the cycle it is due.

// File: rtl/memtype_pkg.sv
`timescale 1ns/1ps
package memtype_pkg;
    localparam int ADDR_W    = 40;
    localparam int PAGE_SH   = 12;
    localparam int PG_W      = ADDR_W - PAGE_SH;
    localparam int TYPE_W    = 8;
    localparam int NFIX      = 88;
    localparam int FIX_WORDS = NFIX / 8;
    localparam int DATA_W    = 64;
    localparam int FIX_IDX_W = $clog2(NFIX);

    localparam logic [TYPE_W-1:0] MT_UC     = 8'h00;
    localparam logic [TYPE_W-1:0] MT_WT     = 8'h04;
    localparam logic [TYPE_W-1:0] MT_WB     = 8'h06;
    localparam logic [TYPE_W-1:0] RES_OFF   = 8'hFF;
    localparam logic [TYPE_W-1:0] RES_SPLIT = 8'hFE;

    typedef struct packed {
        logic              valid;
        logic [PG_W-1:0]   mask_pg;
        logic [PG_W-1:0]   base_pg;
        logic [TYPE_W-1:0] kind;
    } var_rng_t;

    typedef struct packed {
        logic              loaded;
        logic [1:0]        en;
        logic              fix_present;
        logic [TYPE_W-1:0] def_type;
    } ctrl_t;
endpackage

// File: rtl/memtype_cfg.sv
`timescale 1ns/1ps
module memtype_cfg
    import memtype_pkg::*;
#(
    parameter int N_VAR = 8,
    parameter int SEL_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [SEL_W-1:0]            sel,
    input  logic [DATA_W-1:0]           wdata,
    output ctrl_t                       ctrl,
    output logic [ADDR_W-1:0]           tom2,
    output logic [NFIX-1:0][TYPE_W-1:0] fix_types,
    output var_rng_t [N_VAR-1:0]        vars
);
    localparam int SEL_CTRL = 'h00;
    localparam int SEL_LIM  = 'h01;
    localparam int SEL_FIX  = 'h10;
    localparam int SEL_VAR  = 'h40;

    typedef struct packed {
        ctrl_t                       ctrl;
        logic [ADDR_W-1:0]           tom2;
        logic [NFIX-1:0][TYPE_W-1:0] fix;
        var_rng_t [N_VAR-1:0]        vars;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (sel == SEL_W'(SEL_CTRL)) begin
                st_d.ctrl.loaded      = 1'b1;
                st_d.ctrl.en          = wdata[11:10];
                st_d.ctrl.fix_present = wdata[8];
                st_d.ctrl.def_type    = wdata[7:0];
            end
            if (sel == SEL_W'(SEL_LIM))
                st_d.tom2 = wdata[ADDR_W-1:0];
            for (int w = 0; w < FIX_WORDS; w++) begin
                if (sel == SEL_W'(SEL_FIX + w)) begin
                    for (int b = 0; b < 8; b++)
                        st_d.fix[8*w+b] = wdata[8*b +: 8];
                end
            end
            for (int i = 0; i < N_VAR; i++) begin
                if (sel == SEL_W'(SEL_VAR + 2*i)) begin
                    st_d.vars[i].base_pg = wdata[ADDR_W-1:PAGE_SH];
                    st_d.vars[i].kind    = wdata[TYPE_W-1:0];
                end
                if (sel == SEL_W'(SEL_VAR + 2*i + 1)) begin
                    st_d.vars[i].mask_pg = wdata[ADDR_W-1:PAGE_SH];
                    st_d.vars[i].valid   = wdata[11];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl      = st_q.ctrl;
    assign tom2      = st_q.tom2;
    assign fix_types = st_q.fix;
    assign vars      = st_q.vars;

    // R1: once loaded, the configuration stays loaded
    a_r1_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.loaded |=> ctrl.loaded);

    // R10: a control write lands in the following cycle
    a_r10_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_W'(SEL_CTRL)) |=>
            (ctrl.loaded && ctrl.def_type == $past(wdata[7:0])
             && ctrl.en == $past(wdata[11:10])));
endmodule

// File: rtl/memtype_fixed_sel.sv
`timescale 1ns/1ps
module memtype_fixed_sel
    import memtype_pkg::*;
(
    input  logic [PG_W-1:0]             start_pg,
    input  logic [NFIX-1:0][TYPE_W-1:0] fix_types,
    output logic                        in_fixed,
    output logic [TYPE_W-1:0]           fx_type
);
    logic [FIX_IDX_W-1:0] idx;

    always_comb begin
        in_fixed = (start_pg[PG_W-1:8] == '0);
        if (!start_pg[7])
            idx = FIX_IDX_W'(start_pg[6:4]);
        else if (!start_pg[6])
            idx = FIX_IDX_W'(8) + FIX_IDX_W'(start_pg[5:2]);
        else
            idx = FIX_IDX_W'(24) + FIX_IDX_W'(start_pg[5:0]);
        fx_type = fix_types[idx];
    end

    // R2: every fixed-region start maps to an existing byte
    always_comb begin
        if (in_fixed) a_r2_idx_in_table: assert (int'(idx) < NFIX);
    end
endmodule

// File: rtl/memtype_var_scan.sv
`timescale 1ns/1ps
module memtype_var_scan
    import memtype_pkg::*;
#(
    parameter int N_VAR = 8
) (
    input  logic [ADDR_W-1:0]    start_a,
    input  logic [ADDR_W-1:0]    last_a,
    input  var_rng_t [N_VAR-1:0] vars,
    output logic                 term,
    output logic [TYPE_W-1:0]    term_type,
    output logic                 hit,
    output logic [TYPE_W-1:0]    comb_type
);
    logic              done;
    logic [ADDR_W-1:0] maskf, basem;
    logic              s_in, e_in;

    always_comb begin
        done      = 1'b0;
        term      = 1'b0;
        term_type = MT_UC;
        hit       = 1'b0;
        comb_type = MT_UC;
        maskf     = '0;
        basem     = '0;
        s_in      = 1'b0;
        e_in      = 1'b0;
        for (int i = 0; i < N_VAR; i++) begin
            maskf = {vars[i].mask_pg, {PAGE_SH{1'b0}}};
            basem = {vars[i].base_pg, {PAGE_SH{1'b0}}} & maskf;
            s_in  = ((start_a & maskf) == basem);
            e_in  = ((last_a & maskf) == basem);
            if (!done && vars[i].valid) begin
                if (s_in != e_in) begin
                    done      = 1'b1;
                    term      = 1'b1;
                    term_type = RES_SPLIT;
                end else if (s_in) begin
                    if (!hit) begin
                        hit       = 1'b1;
                        comb_type = vars[i].kind;
                    end else if (comb_type == MT_UC || vars[i].kind == MT_UC) begin
                        done = 1'b1;
                        term = 1'b1;
                    end else if ((comb_type == MT_WB && vars[i].kind == MT_WT) ||
                                 (comb_type == MT_WT && vars[i].kind == MT_WB)) begin
                        comb_type = MT_WT;
                    end else if (comb_type != vars[i].kind) begin
                        done = 1'b1;
                        term = 1'b1;
                    end
                end
            end
        end
    end

    // R5 R6: an early stop only ever reports a split or uncacheable
    always_comb begin
        if (term) a_r6_term_code: assert (term_type == MT_UC || term_type == RES_SPLIT);
    end
endmodule

// File: rtl/memtype_resolver.sv
`timescale 1ns/1ps
module memtype_resolver
    import memtype_pkg::*;
#(
    parameter int N_VAR = 8,
    parameter int SEL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [ADDR_W-1:0] lk_start,
    input  logic [ADDR_W-1:0] lk_end,
    output logic              res_valid,
    output logic [TYPE_W-1:0] res_type
);
    localparam logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(64'h1_0000_0000);

    typedef struct packed {
        logic              v;
        logic [TYPE_W-1:0] t;
    } res_t;

    ctrl_t                       ctrl;
    logic [ADDR_W-1:0]           tom2;
    logic [NFIX-1:0][TYPE_W-1:0] fix_types;
    var_rng_t [N_VAR-1:0]        vars;
    logic                        in_fixed, term, hit, acc, high_wb;
    logic [TYPE_W-1:0]           fx_type, term_type, comb_type, rt;
    logic [ADDR_W-1:0]           last_a;
    res_t                        res_d, res_q;

    memtype_cfg #(.N_VAR(N_VAR), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .ctrl(ctrl), .tom2(tom2), .fix_types(fix_types), .vars(vars)
    );

    memtype_fixed_sel u_fix (
        .start_pg(lk_start[ADDR_W-1:PAGE_SH]), .fix_types(fix_types),
        .in_fixed(in_fixed), .fx_type(fx_type)
    );

    memtype_var_scan #(.N_VAR(N_VAR)) u_scan (
        .start_a(lk_start), .last_a(last_a), .vars(vars),
        .term(term), .term_type(term_type), .hit(hit), .comb_type(comb_type)
    );

    assign last_a   = lk_end - ADDR_W'(1);
    assign lk_ready = !cfg_we;
    assign acc      = lk_valid && lk_ready;
    assign high_wb  = (tom2 != '0) && (lk_start >= HIGH_BASE) && (last_a < tom2);

    always_comb begin
        if (!ctrl.loaded || ctrl.en == 2'b00)      rt = RES_OFF;
        else if (ctrl.fix_present && in_fixed)     rt = fx_type;
        else if (!ctrl.en[1])                      rt = ctrl.def_type;
        else if (term)                             rt = term_type;
        else if (high_wb)                          rt = MT_WB;
        else if (hit)                              rt = comb_type;
        else                                       rt = ctrl.def_type;
        res_d.v = acc;
        res_d.t = acc ? rt : res_q.t;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.v;
    assign res_type  = res_q.t;

    a_r9_strobe_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> res_valid);
    a_r9_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !res_valid);
    a_r9_type_held: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(res_type));
    a_r9_no_accept_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !res_valid);
    a_r1_unloaded_off: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ctrl.loaded) |=> res_type == RES_OFF);
endmodule

// File: tb/memtype_resolver_bench.sv
`timescale 1ns/1ps
module memtype_resolver_bench;
    localparam int NV = 8;
    localparam longint M40 = 64'hFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_sel = '0;
    logic [63:0] cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [39:0] lk_start = '0;
    logic [39:0] lk_end = '0;
    logic        res_valid;
    logic [7:0]  res_type;

    memtype_resolver u_memtype_resolver (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_ready(lk_ready),
        .lk_start(lk_start), .lk_end(lk_end), .res_valid(res_valid),
        .res_type(res_type)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0, checking = 0;
    string cur_tag = "R9", exp_tag = "R9";
    bit       exp_v = 0;
    bit [7:0] exp_t = 0;

    // behavioural model state
    bit       m_loaded = 0, m_fixp = 0;
    bit [1:0] m_en = 0;
    bit [7:0] m_def = 0;
    longint   m_tom2 = 0;
    bit [7:0] m_fix [88];
    longint   m_base [NV];
    longint   m_mask [NV];
    bit [7:0] m_kind [NV];
    bit       m_valid [NV];

    function automatic bit [7:0] ref_type(longint s, longint e);
        longint last = (e - 1) & M40;
        int prev = -1;
        if (!m_loaded || m_en == 0) return 8'hFF;
        if (m_fixp && s < 'h100000) begin
            if (s < 'h80000) return m_fix[s / 'h10000];
            if (s < 'hC0000) return m_fix[8 + (s - 'h80000) / 'h4000];
            return m_fix[24 + (s - 'hC0000) / 'h1000];
        end
        if (!m_en[1]) return m_def;
        for (int i = 0; i < NV; i++) begin
            bit sm, em;
            int cur;
            if (!m_valid[i]) continue;
            sm = ((s & m_mask[i]) == (m_base[i] & m_mask[i]));
            em = ((last & m_mask[i]) == (m_base[i] & m_mask[i]));
            if (sm != em) return 8'hFE;
            if (!sm) continue;
            cur = m_kind[i];
            if (prev < 0) begin prev = cur; continue; end
            if (prev == 0 || cur == 0) return 8'h00;
            if ((prev == 6 && cur == 4) || (prev == 4 && cur == 6)) begin prev = 4; cur = 4; end
            if (prev != cur) return 8'h00;
        end
        if (m_tom2 != 0 && s >= 64'h1_0000_0000 && last < m_tom2) return 8'h06;
        if (prev >= 0) return 8'(prev);
        return m_def;
    endfunction

    task automatic check(bit ok, string tag, longint got, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (checking && !done) begin
            check(res_valid == exp_v, "R9 strobe", res_valid, exp_v);
            if (exp_v) check(res_type == exp_t, exp_tag, res_type, exp_t);
            check(lk_ready == !cfg_we, "R9 ready", lk_ready, !cfg_we);
            exp_v = lk_valid && !cfg_we;
            if (exp_v) begin
                exp_t = ref_type(longint'(lk_start), longint'(lk_end));
                exp_tag = cur_tag;
            end
        end
    end

    task automatic model_write(int sel, bit [63:0] d);
        if (sel == 0) begin
            m_loaded = 1; m_en = d[11:10]; m_fixp = d[8]; m_def = d[7:0];
        end else if (sel == 1) m_tom2 = longint'(d[39:0]);
        else if (sel >= 'h10 && sel < 'h10 + 11) begin
            for (int b = 0; b < 8; b++) m_fix[8*(sel-'h10)+b] = d[8*b +: 8];
        end else if (sel >= 'h40 && sel < 'h40 + 2*NV) begin
            int i = (sel - 'h40) / 2;
            if (sel[0] == 0) begin
                m_base[i] = longint'(d[39:12]) << 12; m_kind[i] = d[7:0];
            end else begin
                m_mask[i] = longint'(d[39:12]) << 12; m_valid[i] = d[11];
            end
        end
    endtask

    task automatic wr(int sel, bit [63:0] d, bit with_look = 0);
        @(posedge clk); #2;
        cfg_we = 1; cfg_sel = 8'(sel); cfg_wdata = d; lk_valid = with_look;
        model_write(sel, d);
    endtask

    task automatic look(longint s, longint e, string tag);
        @(posedge clk); #2;
        cfg_we = 0; lk_valid = 1; lk_start = s[39:0]; lk_end = e[39:0]; cur_tag = tag;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #2; cfg_we = 0; lk_valid = 0;
        end
    endtask

    task automatic set_var(int i, longint base, longint size, int kind, bit v, int junk);
        wr('h40 + 2*i, 64'(base | kind | junk));
        wr('h41 + 2*i, 64'(((~(size - 1)) & M40) | (longint'(v) << 11) | junk));
    endtask

    initial begin
        for (int i = 0; i < 88; i++) m_fix[i] = 0;
        for (int i = 0; i < NV; i++) begin
            m_base[i] = 0; m_mask[i] = 0; m_kind[i] = 0; m_valid[i] = 0;
        end
        #35;
        check(res_valid == 0, "R9 reset strobe", res_valid, 0);
        check(lk_ready == 1, "R9 reset ready", lk_ready, 1);
        rst_n = 1;
        @(negedge clk); checking = 1;

        look('h200000, 'h201000, "R1 unloaded");
        wr(0, 64'h003);                       // loaded, enable field zero
        look('h200000, 'h201000, "R1 enable zero");

        for (int w = 0; w < 11; w++) begin
            bit [63:0] d;
            for (int b = 0; b < 8; b++) d[8*b +: 8] = 8'(8*w + b + 'h20);
            wr('h10 + w, d);
        end
        wr(0, 64'hD03);                       // both enables, fixed present, default 3
        look('h00000, 'h00100, "R2 first 64K");
        look('h7FFFF, 'h80000, "R2 top 64K");
        look('h80000, 'h80100, "R2 16K start");
        look('hBFFFF, 'hC0000, "R2 16K end");
        look('hC0000, 'hC0100, "R2 4K start");
        look('hFF000, 'h200000, "R2 4K end, end ignored");
        look('hFFFFF, 'h100000, "R2 last byte");

        wr(0, 64'h503);                       // only low enable bit
        look('h200000, 'h201000, "R3 variable off");

        set_var(0, 'h1000000, 'h1000000, 6, 1, 0);
        set_var(1, 'h1000000, 'h100000, 4, 1, 0);
        set_var(2, 'h2000000, 'h1000000, 0, 1, 0);
        set_var(3, 'h2000000, 'h1000000, 1, 1, 0);
        set_var(4, 'h3100000, 'h100000, 0, 0, 0);
        set_var(5, 'h3000000, 'h100000, 5, 1, 'h300);
        set_var(6, 'h3000000, 'h200000, 1, 1, 0);
        set_var(7, 'h2001000, 'h1000, 0, 1, 0);
        wr(0, 64'hD03);
        look('h1100000, 'h1101000, "R8 single match");
        look('h1000000, 'h1010000, "R6 wb with wt");
        look('h1000000, 'h1200000, "R5 straddle");
        look('h2000000, 'h2001000, "R6 uncacheable wins");
        look('h2000000, 'h2002000, "R6 stop before later straddle");
        look('h3100000, 'h3101000, "R4 invalid skipped");
        look('h3000000, 'h3001000, "R6 mismatch, R4 low bits ignored");
        look('h5000000, 'h5001000, "R8 no match default");
        wr(1, 64'h2_0000_0000);
        look('h1_0000_0000, 'h1_0000_1000, "R7 high write-back");
        look('h1_FFFF_F000, 'h2_0000_0001, "R7 end beyond limit");
        look('h0_F000_0000, 'h0_F000_1000, "R7 below 4G");
        look('h2000000, 'h2001000, "R7 early stop precedes limit");
        wr(0, 64'hC03);                       // fixed not present
        look('h00000, 'h01000, "R2 fixed absent");
        look('hC0000, 'hC1000, "R2 fixed absent 4K");
        wr(0, 64'hD03, 1);                    // lookup offered during write
        look('h1100000, 'h1101000, "R9 after write");
        wr('h3F, 64'hFFFF_FFFF_FFFF_FFFF);    // unmapped selector
        look('h00000, 'h00100, "R10 unmapped ignored");
        look('h3000000, 'h3001000, "R10 unmapped ignored var");
        idle(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule